// File: doc/BRIEF.md
# Flat Pointer Aperture Router

This block sits in front of the memory path for flat shader memory requests. Each request carries a pointer and a payload length in bytes. The block decides whether the access belongs to on-chip shared memory, to per-thread scratch memory, to the driver-managed translation space, or to the system IOMMU space. For the two translated targets it produces a compressed 48-bit address. Alongside that address it gives a translation-select bit (0 = driver page tables, 1 = IOMMU) and a memory-type value that the cache policy tables consume.

Four apertures are described by static configuration inputs: shared, private, driver-VM and spare. Each aperture has a base register and a limit register, and every aperture is 64KB-granular. A two-bit mode selection chooses between three pointer models. In 64-bit driver mode the default space is the driver page tables. In 64-bit system mode and 32-bit system mode the default space is the IOMMU. In 64-bit modes the block flags pointers that fall into the non-canonical hole. In every mode it flags payloads whose first and last bytes land in different apertures.

A single registered stage with a valid/ready handshake on each side separates request from result. A request that breaks a rule is still accepted. It returns with its violation flag set and no target.

Top module: `flat_aperture_router`

## Requirements
- R1: Mode decode. `cfg_xlat_en=1, cfg_ptr32=0` selects 64-bit system mode. `cfg_xlat_en=1, cfg_ptr32=1` selects 32-bit system mode. `cfg_xlat_en=0` selects 64-bit driver mode whatever `cfg_ptr32` holds. Default-space requests return `rsp_sys=1` and target code 4 in both system modes. They return `rsp_sys=0` and target code 3 in driver mode.
- R2: An aperture spans from its base register with bits [15:0] replaced by zero up to its limit register with bits [15:0] replaced by ones. Both ends are inclusive.
- R3: A pointer inside the driver-VM aperture gives target code 3 and `rsp_sys=0`. Its address is the pointer minus the effective driver-VM base, kept to the low 40 bits with bits [47:40] zero.
- R4: A pointer that hits no aperture goes to the default space. In system modes the address is pointer bits [47:0]. In driver mode the address is pointer bits [39:0], zero-extended. The memory type is `cfg_default_mtype`.
- R5: In the 64-bit modes, a byte that hits no aperture is a violation if its bits [63:47] are neither all zero nor all ones.
- R6: The last byte is at pointer + length − 1, and a length of 0 counts as 1. A violation is raised in either of two cases: the first and last bytes match different sets of apertures, or the last byte passes the top of the pointer space (2^64 in 64-bit modes, 2^32 in 32-bit mode).
- R7: A hit on the shared aperture gives target code 1, and a hit on the private aperture gives target code 2. Both return address 0, `rsp_sys=0` and memory type 0.
- R8: In 32-bit mode the pointer is bits [31:0] zero-extended. The shared and private windows are 64KB, starting at base-register bits [31:16] << 16, and their limit registers are ignored. A window is disabled when those base bits are zero. There is no hole check in this mode.
- R9: In the 64-bit modes a hit on the spare aperture is routed like the default space but carries `cfg_spare_mtype`. In 32-bit mode the spare aperture never matches.
- R10: If the first byte matches several apertures, the winner is chosen in priority order: shared, then private, then driver-VM, then spare. `rsp_cfg_err` is raised in that case.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request appears on the outputs at the next clock edge. The outputs hold steady while `rsp_valid && !rsp_ready`. A violation returns target 0, address 0 and `rsp_sys=0`.
- R12: While `rst` is high, `rsp_valid` is cleared on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ptr | input | 64 | Flat pointer (low 32 bits used in 32-bit mode) |
| req_bytes | input | LEN_W | Payload length in bytes, 0 treated as 1 |
| cfg_xlat_en | input | 1 | Translation-enable mode bit |
| cfg_ptr32 | input | 1 | 32-bit pointer mode bit |
| cfg_shared_base | input | 64 | Shared aperture base register |
| cfg_shared_limit | input | 64 | Shared aperture limit register |
| cfg_private_base | input | 64 | Private aperture base register |
| cfg_private_limit | input | 64 | Private aperture limit register |
| cfg_drv_base | input | 64 | Driver-VM aperture base register |
| cfg_drv_limit | input | 64 | Driver-VM aperture limit register |
| cfg_spare_base | input | 64 | Spare aperture base register |
| cfg_spare_limit | input | 64 | Spare aperture limit register |
| cfg_spare_mtype | input | MT_W | Memory type for spare-aperture hits |
| cfg_default_mtype | input | MT_W | Memory type for other translated accesses |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_target | output | 3 | 0 none, 1 shared, 2 private, 3 driver space, 4 IOMMU space |
| rsp_addr | output | OUT_AW | Compressed translated address |
| rsp_sys | output | 1 | Translation-select bit |
| rsp_mtype | output | MT_W | Memory type |
| rsp_violation | output | 1 | Memory violation |
| rsp_cfg_err | output | 1 | Overlapping apertures matched |

## Verification
The assertions check several handshake and result rules on every cycle. They cover the handshake rules: the hold under back-pressure, the one-cycle latency and the reset clear. They also check that a violation leaves no target, that on-chip targets carry no address, that driver-space addresses stay below 2^40, and that an IOMMU target only appears with translation enabled. Whether a given pointer lands in the right aperture depends on its value and the configuration together. The bench scenarios alone show that: inclusive edges and forced low bits, the hole, payloads that straddle an edge or wrap, the 32-bit windows and their disable, the spare memory type and overlap priority.

// File: rtl/far_pkg.sv
package far_pkg;

    localparam int PTR_W     = 64;
    localparam int GRAN_BITS = 16;
    localparam int CANON_MSB = 47;
    localparam int NUM_APE   = 4;
    localparam int APE_IW    = $clog2(NUM_APE);
    localparam int TGT_W     = 3;

    // Aperture slots; the index order is the match priority.
    localparam int APE_SHARED  = 0;
    localparam int APE_PRIVATE = 1;
    localparam int APE_DRV     = 2;
    localparam int APE_SPARE   = 3;

    typedef enum logic [1:0] {
        MODE_DRV64 = 2'd0,
        MODE_SYS64 = 2'd1,
        MODE_SYS32 = 2'd2
    } mode_e;

    typedef enum logic [TGT_W-1:0] {
        TGT_NONE    = 3'd0,
        TGT_SHARED  = 3'd1,
        TGT_PRIVATE = 3'd2,
        TGT_DRV     = 3'd3,
        TGT_SYS     = 3'd4
    } tgt_e;

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] lo;
        logic [PTR_W-1:0] hi;
    } ape_win_t;

    typedef struct packed {
        logic [NUM_APE-1:0] hits;
        logic               hole;
    } ep_class_t;

    function automatic mode_e decode_mode(input logic xlat_en, input logic ptr32);
        if (!xlat_en)  return MODE_DRV64;
        else if (ptr32) return MODE_SYS32;
        else            return MODE_SYS64;
    endfunction

    function automatic logic [PTR_W-1:0] gran_floor(input logic [PTR_W-1:0] r);
        return {r[PTR_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
    endfunction

    function automatic logic [PTR_W-1:0] gran_ceil(input logic [PTR_W-1:0] r);
        return {r[PTR_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
    endfunction

endpackage

// File: rtl/far_win_match.sv
module far_win_match
    import far_pkg::*;
(
    input  ape_win_t         win,
    input  logic [PTR_W-1:0] addr,
    output logic             hit
);
    always_comb begin
        hit = win.en && (addr >= win.lo) && (addr <= win.hi);
    end
endmodule

// File: rtl/far_endpoint.sv
module far_endpoint
    import far_pkg::*;
(
    input  mode_e            mode,
    input  ape_win_t         wins [NUM_APE],
    input  logic [PTR_W-1:0] addr,
    output ep_class_t        cls
);
    logic [NUM_APE-1:0] hit_vec;
    logic               canonical;

    for (genvar g = 0; g < NUM_APE; g++) begin : g_win
        far_win_match u_match (
            .win  (wins[g]),
            .addr (addr),
            .hit  (hit_vec[g])
        );
    end

    always_comb begin
        canonical = (addr[PTR_W-1:CANON_MSB] == '0) || (&addr[PTR_W-1:CANON_MSB]);
        cls.hits  = hit_vec;
        cls.hole  = (mode != MODE_SYS32) && (hit_vec == '0) && !canonical;
    end
endmodule

// File: rtl/far_route.sv
module far_route
    import far_pkg::*;
#(
    parameter int OUT_AW = 48,
    parameter int DRV_AW = 40,
    parameter int MT_W   = 2
) (
    input  mode_e             mode,
    input  logic [PTR_W-1:0]  first_addr,
    input  ep_class_t         first_cls,
    input  ep_class_t         last_cls,
    input  logic              overflow,
    input  logic [PTR_W-1:0]  drv_lo,
    input  logic [MT_W-1:0]   spare_mtype,
    input  logic [MT_W-1:0]   default_mtype,
    output tgt_e              tgt,
    output logic [OUT_AW-1:0] addr,
    output logic              sys,
    output logic [MT_W-1:0]   mtype,
    output logic              viol,
    output logic              cfg_err
);
    localparam int PAD_W = OUT_AW - DRV_AW;

    logic               def_sys;
    logic [PTR_W-1:0]   drv_off;
    logic [APE_IW-1:0]  win_idx;
    logic               win_any;
    logic [OUT_AW-1:0]  def_addr;

    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int i = NUM_APE - 1; i >= 0; i--) begin
            if (first_cls.hits[i]) begin
                win_any = 1'b1;
                win_idx = APE_IW'(i);
            end
        end
    end

    always_comb begin
        def_sys  = (mode != MODE_DRV64);
        drv_off  = first_addr - drv_lo;
        def_addr = def_sys ? first_addr[OUT_AW-1:0]
                           : {{PAD_W{1'b0}}, first_addr[DRV_AW-1:0]};
        viol     = overflow || first_cls.hole || last_cls.hole
                   || (first_cls.hits != last_cls.hits);
        cfg_err  = ($countones(first_cls.hits) > 1);

        tgt   = TGT_NONE;
        addr  = '0;
        sys   = 1'b0;
        mtype = '0;
        if (!viol) begin
            if (win_any && (int'(win_idx) == APE_SHARED)) begin
                tgt = TGT_SHARED;
            end else if (win_any && (int'(win_idx) == APE_PRIVATE)) begin
                tgt = TGT_PRIVATE;
            end else if (win_any && (int'(win_idx) == APE_DRV)) begin
                tgt   = TGT_DRV;
                addr  = {{PAD_W{1'b0}}, drv_off[DRV_AW-1:0]};
                mtype = default_mtype;
            end else begin
                tgt   = def_sys ? TGT_SYS : TGT_DRV;
                addr  = def_addr;
                sys   = def_sys;
                mtype = (win_any && (int'(win_idx) == APE_SPARE)) ? spare_mtype
                                                                 : default_mtype;
            end
        end
    end
endmodule

// File: rtl/flat_aperture_router.sv
module flat_aperture_router
    import far_pkg::*;
#(
    parameter int LEN_W  = 8,
    parameter int OUT_AW = 48,
    parameter int DRV_AW = 40,
    parameter int MT_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [63:0]       req_ptr,
    input  logic [LEN_W-1:0]  req_bytes,
    input  logic              cfg_xlat_en,
    input  logic              cfg_ptr32,
    input  logic [63:0]       cfg_shared_base,
    input  logic [63:0]       cfg_shared_limit,
    input  logic [63:0]       cfg_private_base,
    input  logic [63:0]       cfg_private_limit,
    input  logic [63:0]       cfg_drv_base,
    input  logic [63:0]       cfg_drv_limit,
    input  logic [63:0]       cfg_spare_base,
    input  logic [63:0]       cfg_spare_limit,
    input  logic [MT_W-1:0]   cfg_spare_mtype,
    input  logic [MT_W-1:0]   cfg_default_mtype,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [2:0]        rsp_target,
    output logic [OUT_AW-1:0] rsp_addr,
    output logic              rsp_sys,
    output logic [MT_W-1:0]   rsp_mtype,
    output logic              rsp_violation,
    output logic              rsp_cfg_err
);
    localparam int SUM_W  = PTR_W + 1;
    localparam int HALF_W = PTR_W / 2;

    mode_e             mode;
    logic              narrow;
    logic [PTR_W-1:0]  ptr_first;
    logic [PTR_W-1:0]  ptr_last;
    logic [SUM_W-1:0]  end_sum;
    logic [SUM_W-1:0]  len_ext;
    logic              overflow;
    ape_win_t          wins [NUM_APE];
    ep_class_t         cls_first;
    ep_class_t         cls_last;

    tgt_e              n_tgt;
    logic [OUT_AW-1:0] n_addr;
    logic              n_sys;
    logic [MT_W-1:0]   n_mtype;
    logic              n_viol;
    logic              n_cfg_err;
    logic              take;

    // Mode and pointer normalisation
    always_comb begin
        mode      = decode_mode(cfg_xlat_en, cfg_ptr32);
        narrow    = (mode == MODE_SYS32);
        ptr_first = narrow ? {{HALF_W{1'b0}}, req_ptr[HALF_W-1:0]} : req_ptr;
        len_ext   = (req_bytes == '0) ? SUM_W'(1) : SUM_W'(req_bytes);
        end_sum   = {1'b0, ptr_first} + len_ext - SUM_W'(1);
        ptr_last  = end_sum[PTR_W-1:0];
        overflow  = narrow ? (|end_sum[SUM_W-1:HALF_W]) : end_sum[SUM_W-1];
    end

    // Effective aperture windows for the current mode
    function automatic ape_win_t small_win(input logic [63:0] base_reg);
        ape_win_t w;
        w.en = |base_reg[HALF_W-1:GRAN_BITS];
        w.lo = {{HALF_W{1'b0}}, base_reg[HALF_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
        w.hi = {{HALF_W{1'b0}}, base_reg[HALF_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
        return w;
    endfunction

    function automatic ape_win_t wide_win(input logic [63:0] base_reg,
                                          input logic [63:0] limit_reg,
                                          input logic        enable);
        ape_win_t w;
        w.en = enable;
        w.lo = gran_floor(base_reg);
        w.hi = gran_ceil(limit_reg);
        return w;
    endfunction

    always_comb begin
        wins[APE_SHARED]  = narrow ? small_win(cfg_shared_base)
                                   : wide_win(cfg_shared_base, cfg_shared_limit, 1'b1);
        wins[APE_PRIVATE] = narrow ? small_win(cfg_private_base)
                                   : wide_win(cfg_private_base, cfg_private_limit, 1'b1);
        wins[APE_DRV]     = wide_win(cfg_drv_base, cfg_drv_limit, 1'b1);
        wins[APE_SPARE]   = wide_win(cfg_spare_base, cfg_spare_limit, !narrow);
    end

    far_endpoint u_ep_first (
        .mode (mode),
        .wins (wins),
        .addr (ptr_first),
        .cls  (cls_first)
    );

    far_endpoint u_ep_last (
        .mode (mode),
        .wins (wins),
        .addr (ptr_last),
        .cls  (cls_last)
    );

    far_route #(
        .OUT_AW (OUT_AW),
        .DRV_AW (DRV_AW),
        .MT_W   (MT_W)
    ) u_route (
        .mode          (mode),
        .first_addr    (ptr_first),
        .first_cls     (cls_first),
        .last_cls      (cls_last),
        .overflow      (overflow),
        .drv_lo        (wins[APE_DRV].lo),
        .spare_mtype   (cfg_spare_mtype),
        .default_mtype (cfg_default_mtype),
        .tgt           (n_tgt),
        .addr          (n_addr),
        .sys           (n_sys),
        .mtype         (n_mtype),
        .viol          (n_viol),
        .cfg_err       (n_cfg_err)
    );

    // Single result register with pass-through back-pressure
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        take      = req_valid && req_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_target    <= TGT_NONE;
            rsp_addr      <= '0;
            rsp_sys       <= 1'b0;
            rsp_mtype     <= '0;
            rsp_violation <= 1'b0;
            rsp_cfg_err   <= 1'b0;
        end else if (req_ready) begin
            rsp_valid <= take;
            if (take) begin
                rsp_target    <= n_tgt;
                rsp_addr      <= n_addr;
                rsp_sys       <= n_sys;
                rsp_mtype     <= n_mtype;
                rsp_violation <= n_viol;
                rsp_cfg_err   <= n_cfg_err;
            end
        end
    end
endmodule

// File: rtl/far_checker.sv
module far_checker #(
    parameter int OUT_AW = 48,
    parameter int DRV_AW = 40,
    parameter int MT_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              cfg_xlat_en,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [2:0]        rsp_target,
    input logic [OUT_AW-1:0] rsp_addr,
    input logic              rsp_sys,
    input logic [MT_W-1:0]   rsp_mtype,
    input logic              rsp_violation
);
    // R12: reset empties the result stage
    assert_reset_idle_R12: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    // R11: accepted request shows up one edge later
    assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);

    // R11: stalled result holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_target)
            && $stable(rsp_addr) && $stable(rsp_sys) && $stable(rsp_mtype)
            && $stable(rsp_violation)));

    // R11: violation carries no target
    assert_viol_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_violation) |->
            (rsp_target == 3'd0 && rsp_addr == '0 && !rsp_sys));

    // R7: on-chip targets carry no translated address
    assert_onchip_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_target == 3'd1 || rsp_target == 3'd2)) |->
            (rsp_addr == '0 && !rsp_sys && rsp_mtype == '0));

    // R3: driver-space addresses fit the driver width
    assert_drv_width_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_target == 3'd3) |->
            (rsp_addr[OUT_AW-1:DRV_AW] == '0 && !rsp_sys));

    // R1: IOMMU target only with translation enabled
    assert_sys_mode_R1: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_target == 3'd4) |-> (rsp_sys && cfg_xlat_en));

    // R11: target code stays in range
    assert_tgt_range_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_target <= 3'd4));
endmodule

bind flat_aperture_router far_checker #(
    .OUT_AW (OUT_AW),
    .DRV_AW (DRV_AW),
    .MT_W   (MT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .cfg_xlat_en   (cfg_xlat_en),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_target    (rsp_target),
    .rsp_addr      (rsp_addr),
    .rsp_sys       (rsp_sys),
    .rsp_mtype     (rsp_mtype),
    .rsp_violation (rsp_violation)
);

// File: tb/sim_flat_aperture_router.sv
`timescale 1ns/1ps
module sim_flat_aperture_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_ptr = '0;
    logic [7:0]  req_bytes = '0;
    logic        cfg_xlat_en = 1'b0, cfg_ptr32 = 1'b0;
    logic [63:0] cfg_shared_base = '0, cfg_shared_limit = '0;
    logic [63:0] cfg_private_base = '0, cfg_private_limit = '0;
    logic [63:0] cfg_drv_base = '0, cfg_drv_limit = '0;
    logic [63:0] cfg_spare_base = '0, cfg_spare_limit = '0;
    logic [1:0]  cfg_spare_mtype = 2'd2, cfg_default_mtype = 2'd1;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [2:0]  rsp_target;
    logic [47:0] rsp_addr;
    logic        rsp_sys;
    logic [1:0]  rsp_mtype;
    logic        rsp_violation;
    logic        rsp_cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit bp_on    = 1'b0;

    typedef struct {
        logic [2:0]  tgt;
        logic [47:0] addr;
        logic        sys;
        logic [1:0]  mt;
        logic        viol;
        logic        cerr;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #4 clk = ~clk;

    flat_aperture_router u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ptr(req_ptr), .req_bytes(req_bytes),
        .cfg_xlat_en(cfg_xlat_en), .cfg_ptr32(cfg_ptr32),
        .cfg_shared_base(cfg_shared_base), .cfg_shared_limit(cfg_shared_limit),
        .cfg_private_base(cfg_private_base), .cfg_private_limit(cfg_private_limit),
        .cfg_drv_base(cfg_drv_base), .cfg_drv_limit(cfg_drv_limit),
        .cfg_spare_base(cfg_spare_base), .cfg_spare_limit(cfg_spare_limit),
        .cfg_spare_mtype(cfg_spare_mtype), .cfg_default_mtype(cfg_default_mtype),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_target(rsp_target),
        .rsp_addr(rsp_addr), .rsp_sys(rsp_sys), .rsp_mtype(rsp_mtype),
        .rsp_violation(rsp_violation), .rsp_cfg_err(rsp_cfg_err)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic void window(input int i, input bit s32,
                                   output logic [63:0] lo, output logic [63:0] hi,
                                   output bit en);
        logic [63:0] b, l;
        case (i)
            0: begin b = cfg_shared_base;  l = cfg_shared_limit;  end
            1: begin b = cfg_private_base; l = cfg_private_limit; end
            2: begin b = cfg_drv_base;     l = cfg_drv_limit;     end
            default: begin b = cfg_spare_base; l = cfg_spare_limit; end
        endcase
        if (s32 && i < 2) begin       // R8 small windows
            en = (b[31:16] != 16'h0);
            lo = {32'h0, b[31:16], 16'h0};
            hi = lo + 64'hFFFF;
        end else begin                // R2 granular bounds, R9 spare off in 32-bit
            en = !(s32 && i == 3);
            lo = b & ~64'hFFFF;
            hi = l | 64'hFFFF;
        end
    endfunction

    function automatic logic [3:0] hitset(input logic [63:0] a, input bit s32);
        logic [3:0] h = '0;
        for (int i = 0; i < 4; i++) begin
            logic [63:0] lo, hi;
            bit en;
            window(i, s32, lo, hi, en);
            h[i] = en && a >= lo && a <= hi;
        end
        return h;
    endfunction

    function automatic exp_t model(input logic [63:0] ptr, input logic [7:0] nb,
                                   input string tag);
        exp_t e;
        bit s32 = cfg_xlat_en && cfg_ptr32;
        logic [63:0] a0 = s32 ? {32'h0, ptr[31:0]} : ptr;
        logic [64:0] last = {1'b0, a0} + 65'(((nb == 0) ? 8'd1 : nb)) - 65'd1;
        bit ovf = s32 ? (last[64:32] != 0) : last[64];
        logic [3:0] h0 = hitset(a0, s32);
        logic [3:0] h1 = hitset(last[63:0], s32);
        bit hole0 = !s32 && h0 == 0 && !(a0[63:47] == 17'h0 || a0[63:47] == 17'h1FFFF);
        bit hole1 = !s32 && h1 == 0 && !(last[63:47] == 17'h0 || last[63:47] == 17'h1FFFF);
        logic [63:0] dlo, dhi, diff;
        bit den;
        window(2, s32, dlo, dhi, den);
        e.tag  = tag;
        e.viol = ovf || hole0 || hole1 || (h0 != h1);
        e.cerr = ($countones(h0) > 1);
        e.tgt = 0; e.addr = 0; e.sys = 0; e.mt = 0;
        if (!e.viol) begin
            if (h0[0]) e.tgt = 1;
            else if (h0[1]) e.tgt = 2;
            else if (h0[2]) begin
                diff   = a0 - dlo;
                e.tgt  = 3;
                e.addr = {8'h0, diff[39:0]};
                e.mt   = cfg_default_mtype;
            end else begin
                e.sys  = cfg_xlat_en;
                e.tgt  = cfg_xlat_en ? 3'd4 : 3'd3;
                e.addr = cfg_xlat_en ? a0[47:0] : {8'h0, a0[39:0]};
                e.mt   = h0[3] ? cfg_spare_mtype : cfg_default_mtype;
            end
        end
        return e;
    endfunction

    // ---------------- driver ----------------
    task automatic send(input logic [63:0] ptr, input logic [7:0] nb, input string tag);
        exp_q.push_back(model(ptr, nb, tag));
        @(negedge clk);
        req_valid = 1'b1;
        req_ptr   = ptr;
        req_bytes = nb;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // back-pressure pattern
    always @(negedge clk) begin
        cyc <= cyc + 1;
        rsp_ready = bp_on ? (cyc[0] ^ cyc[2]) : 1'b1;
    end

    // ---------------- monitor / scoreboard ----------------
    logic        held = 1'b0;
    logic [55:0] held_val;
    always @(negedge clk) begin
        #2;
        if (!rst && held) begin
            n_checks++;
            if (!rsp_valid || held_val != {rsp_target, rsp_addr, rsp_sys, rsp_mtype, rsp_violation, rsp_cfg_err}) begin
                n_fails++;
                $display("FAIL R11 stall hold: actual %h expected %h", {rsp_target, rsp_addr, rsp_sys, rsp_mtype, rsp_violation, rsp_cfg_err}, held_val);
            end
        end
        held     = !rst && rsp_valid && !rsp_ready;
        held_val = {rsp_target, rsp_addr, rsp_sys, rsp_mtype, rsp_violation, rsp_cfg_err};
        if (!rst && rsp_valid && rsp_ready) begin
            exp_t e;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R11 unexpected result: actual tgt=%0d expected none", rsp_target);
            end else begin
                e = exp_q.pop_front();
                if (rsp_target !== e.tgt || rsp_addr !== e.addr || rsp_sys !== e.sys ||
                    rsp_mtype !== e.mt || rsp_violation !== e.viol || rsp_cfg_err !== e.cerr) begin
                    n_fails++;
                    $display("FAIL %s: actual tgt=%0d addr=%h sys=%b mt=%0d viol=%b cerr=%b expected tgt=%0d addr=%h sys=%b mt=%0d viol=%b cerr=%b",
                        e.tag, rsp_target, rsp_addr, rsp_sys, rsp_mtype, rsp_violation, rsp_cfg_err,
                        e.tgt, e.addr, e.sys, e.mt, e.viol, e.cerr);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_up();
    end

    task automatic base_cfg();
        cfg_shared_base  = 64'h0001_0000_0000_0000;
        cfg_shared_limit = 64'h0001_0000_FFFF_0000;   // low bits forced to ones (R2)
        cfg_private_base = 64'h0002_0000_0000_0000;
        cfg_private_limit= 64'h0002_0000_FFFF_FFFF;
        cfg_drv_base     = 64'h1000_0000_0000_ABCD;   // low bits forced to zero (R2)
        cfg_drv_limit    = 64'h1000_00FF_FFFF_FFFF;
        cfg_spare_base   = 64'h0000_7000_0000_0000;
        cfg_spare_limit  = 64'h0000_7000_0001_0000;
    endtask

    initial begin
        base_cfg();
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        n_checks++;   // R12 reset state
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            n_fails++;
            $display("FAIL R12 reset: actual valid=%b ready=%b expected valid=0 ready=1", rsp_valid, req_ready);
        end
        rst = 1'b0;

        // Driver mode, ptr32 set but ignored (R1)
        cfg_xlat_en = 1'b0; cfg_ptr32 = 1'b1;
        send(64'h0001_0000_0000_0000, 8'd4, "R7 shared at base");
        send(64'h0002_0000_FFFF_FFFF, 8'd1, "R7 private at limit");
        send(64'h0001_0000_FFFF_FFFF, 8'd1, "R2 limit low bits forced");
        send(64'h0001_0001_0000_0000, 8'd1, "R5 one past limit in hole");
        send(64'h1000_0000_0000_1234, 8'd8, "R3 driver hit offset");
        send(64'h0000_1234_5678_9ABC, 8'd4, "R4 driver default 40 bit");
        send(64'h0000_7000_0001_FFF0, 8'd16, "R9 spare mtype");
        send(64'h0000_6FFF_FFFF_FFFF, 8'd1, "R2 below spare base");
        send(64'h4000_0000_0000_0000, 8'd4, "R5 hole");
        send(64'h0001_0000_FFFF_FFFC, 8'd8, "R6 straddle edge");
        send(64'hFFFF_8000_0000_0010, 8'd0, "R1 high canonical zero len");
        send(64'hFFFF_FFFF_FFFF_FFF0, 8'd32, "R6 wrap past top");
        drain();

        // 64-bit system mode (R1)
        cfg_xlat_en = 1'b1; cfg_ptr32 = 1'b0;
        send(64'h0000_1234_5678_9ABC, 8'd4, "R1 system default");
        send(64'h1000_0000_0000_0040, 8'd4, "R3 driver hit in system mode");
        send(64'h0000_7000_0000_0000, 8'd4, "R9 spare in system mode");
        send(64'h8000_0000_0000_0000, 8'd1, "R5 hole system mode");
        drain();

        // 32-bit system mode (R8)
        cfg_ptr32        = 1'b1;
        cfg_shared_base  = 64'hFFFF_0000_0003_1234;
        cfg_private_base = 64'h0000_0000_0000_FFFF;   // bits [31:16] zero: disabled
        cfg_drv_base     = 64'h0000_0000_8000_0000;
        cfg_drv_limit    = 64'h0000_0000_8FFF_FFFF;
        cfg_spare_base   = 64'h0;
        cfg_spare_limit  = 64'h0000_0000_0000_FFFF;
        send(64'hDEAD_BEEF_0003_0010, 8'd4, "R8 shared window upper ignored");
        send(64'h0000_0000_0003_FFFF, 8'd1, "R8 shared window top");
        send(64'h0000_0000_0004_0000, 8'd1, "R8 past shared window");
        send(64'h0000_0000_0000_0100, 8'd4, "R9 spare off in 32-bit");
        send(64'h0000_0000_8000_0010, 8'd4, "R3 driver 32-bit");
        send(64'h0000_0000_FFFF_FFF8, 8'd16, "R6 32-bit wrap");
        send(64'h0000_0000_0003_FFFE, 8'd4, "R6 32-bit straddle");
        drain();

        // Overlap priority (R10)
        cfg_ptr32 = 1'b0;
        base_cfg();
        cfg_shared_base  = 64'h1000_0000_0000_0000;
        cfg_shared_limit = 64'h1000_0000_0000_0000;
        send(64'h1000_0000_0000_0100, 8'd4, "R10 shared over driver");
        send(64'h1000_0000_0001_0000, 8'd4, "R10 driver alone");
        drain();

        // Back-pressure stream (R11)
        bp_on = 1'b1;
        for (int k = 0; k < 24; k++)
            send(64'h0000_0000_0100_0000 + 64'(k) * 64'h1_0008, 8'(k), "R11 stream");
        drain();
        bp_on = 1'b0;
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule